// File: doc/BRIEF.md
# Transmit Completion Poller

This controller runs one packet transmission from start to finish. It sits above a command master that carries out serial radio commands. The controller drives that master through a request/acknowledge port. A one-cycle start pulse makes it issue a single-shot transmit command. It then reads the 16-bit interrupt status word again and again until the transmit-done flag is set or a timeout runs out.

Whichever way the polling ends, the controller sends an interrupt-clear command that targets only the transmit-done flag. It then pulses `done`, with `ok` showing success or timeout. Loading the payload and setting the packet parameters are the job of other logic.

Each command is given by an opcode, a count of parameter bytes to write, a count of bytes to read back, and up to three parameter bytes. The first parameter byte is `cmd_par[23:16]`, the second `[15:8]` and the third `[7:0]`. The master returns the last two bytes it reads on `cmd_rdata`. The second byte read sits in `[7:0]`, and that byte holds the flags.

Top module: `tx_done_poller`

## Requirements
- R1: A `start` pulse sampled while idle raises `cmd_req` on the next cycle. That first command has opcode 0x83, three write bytes, all parameter bytes 0x00, and zero read bytes.
- R2: Once `cmd_req` is high it stays high, with opcode, counts and parameters unchanged, until a cycle in which `cmd_ack` is high.
- R3: After the transmit command is acknowledged, the block issues status reads. Each read has opcode 0x12, zero write bytes and two read bytes. A new read is issued after each acknowledged read that does not end the polling.
- R4: Only bit 0 of `cmd_rdata[7:0]` means transmit-done. A status word of 0xFFFE does not end the polling.
- R5: The block counts clock cycles from the sampled start. A status read that returns bit 0 clear once `TIMEOUT_CYCLES` cycles have passed ends the polling.
- R6: The polling ends on either path with exactly one clear command. It has opcode 0x02, two write bytes, first byte 0x00, second byte 0x01, and zero read bytes.
- R7: `done` is high for exactly one cycle, the cycle after the clear command is acknowledged. `busy` is low in that same cycle.
- R8: `ok` is 1 at `done` if transmit-done was seen and 0 on timeout. It holds until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored. It starts no second transmit command and adds no extra status reads.
- R10: The timeout count restarts at every accepted start. A second timeout run therefore waits the full window again.
- R11: After reset, `cmd_req`, `busy`, `done` and `ok` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to run a transmission |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| ok | output | 1 | 1 = transmit-done seen, 0 = timeout |
| cmd_req | output | 1 | Command request to the master |
| cmd_ack | input | 1 | Master has finished the command (one cycle) |
| cmd_op | output | 8 | Command opcode |
| cmd_nwr | output | 2 | Number of parameter bytes to write |
| cmd_nrd | output | 2 | Number of bytes to read back |
| cmd_par | output | 24 | Parameter bytes, first byte in [23:16] |
| cmd_rdata | input | 16 | Read-back bytes; flag byte in [7:0] |

## Verification
`cmd_req` with the transmit opcode is due one cycle after `start` is sampled. Each following command appears in the cycle right after the previous acknowledge. `done` and the falling `busy` come one cycle after the clear acknowledge. The bench drives inputs and samples outputs on the falling edge only. Its responder model applies its acknowledge latency counted in whole cycles. The bench therefore reads each result at the first falling edge after the rising edge that registers it. Timeout runs are checked by the elapsed cycle count between the sampled start and `done`, and by the number of status reads.

// File: rtl/tx_done_poller.sv
module tx_done_poller #(
  parameter int TIMEOUT_CYCLES = 1000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  output logic        busy,
  output logic        done,
  output logic        ok,
  output logic        cmd_req,
  input  logic        cmd_ack,
  output logic [7:0]  cmd_op,
  output logic [1:0]  cmd_nwr,
  output logic [1:0]  cmd_nrd,
  output logic [23:0] cmd_par,
  input  logic [15:0] cmd_rdata
);

  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [TW-1:0] TLIM = TW'(TIMEOUT_CYCLES);

  localparam logic [7:0] OP_TX    = 8'h83;
  localparam logic [7:0] OP_STAT  = 8'h12;
  localparam logic [7:0] OP_CLEAR = 8'h02;

  typedef enum logic [1:0] {S_IDLE, S_TX, S_POLL, S_CLR} st_t;

  st_t           st;
  logic [TW-1:0] tick;
  logic          ok_q, done_q;
  logic          expired;

  assign expired = (tick == TLIM);
  assign busy    = (st != S_IDLE);
  assign cmd_req = busy;
  assign done    = done_q;
  assign ok      = ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      tick   <= '0;
      ok_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (busy && !expired) tick <= tick + 1'b1;
      case (st)
        S_IDLE: if (start) begin
          st   <= S_TX;
          tick <= '0;
          ok_q <= 1'b0;
        end
        S_TX: if (cmd_ack) st <= S_POLL;
        S_POLL: if (cmd_ack) begin
          if (cmd_rdata[0]) begin
            ok_q <= 1'b1;
            st   <= S_CLR;
          end else if (expired) begin
            st <= S_CLR;
          end
        end
        S_CLR: if (cmd_ack) begin
          st     <= S_IDLE;
          done_q <= 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd_op  = 8'h00;
    cmd_nwr = 2'd0;
    cmd_nrd = 2'd0;
    cmd_par = 24'h000000;
    case (st)
      S_TX:   begin cmd_op = OP_TX;    cmd_nwr = 2'd3; end
      S_POLL: begin cmd_op = OP_STAT;  cmd_nrd = 2'd2; end
      S_CLR:  begin cmd_op = OP_CLEAR; cmd_nwr = 2'd2; cmd_par = 24'h000100; end
      default: ;
    endcase
  end

  p_tx_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_req && cmd_op == OP_TX && cmd_par == 24'h0));

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && !cmd_ack) |=> (cmd_req && $stable(cmd_op) && $stable(cmd_par)));

  p_rdata_known_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ack && cmd_op == OP_STAT) |-> !$isunknown(cmd_rdata));

  p_poll_goes_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_POLL && cmd_ack && !cmd_rdata[0] && !expired) |=> (cmd_op == OP_STAT));

  p_fail_only_late_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !ok) |-> expired);

  p_done_after_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(cmd_ack) && $past(cmd_op) == OP_CLEAR && !busy));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(st == S_CLR && cmd_ack)) |=> busy);

endmodule

// File: tb/tx_done_poller_bench.sv
module tx_done_poller_bench;
  localparam int TMO = 300;
  localparam int NV  = 6;
  localparam int VLAT [NV] = '{0, 2, 1, 5, 0, 3};
  localparam int VDA  [NV] = '{0, 3, 7, 1, 9999, 9999};
  localparam int VOK  [NV] = '{1, 1, 1, 1, 0, 0};

  logic clk = 0, rst_n = 0, start = 0, cmd_ack = 0;
  logic [15:0] cmd_rdata = 16'h0;
  logic busy, done, ok, cmd_req;
  logic [7:0] cmd_op;
  logic [1:0] cmd_nwr, cmd_nrd;
  logic [23:0] cmd_par;

  always #10 clk = ~clk;

  tx_done_poller #(.TIMEOUT_CYCLES(TMO)) u_tx_done_poller (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .ok(ok),
    .cmd_req(cmd_req), .cmd_ack(cmd_ack), .cmd_op(cmd_op), .cmd_nwr(cmd_nwr),
    .cmd_nrd(cmd_nrd), .cmd_par(cmd_par), .cmd_rdata(cmd_rdata));

  int nchk = 0, nfail = 0, cyc = 0;
  int lat = 0, done_after = 0, wcnt = 0;
  int tx_seen = 0, poll_seen = 0, clr_seen = 0, bad_fmt = 0;
  logic [23:0] clr_par;

  task automatic chk(input bit good, input string tag, input int act, input int exp);
    nchk++;
    if (!good) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cmd_ack) cmd_ack = 0;
    else if (cmd_req) begin
      if (wcnt < lat) wcnt++;
      else begin
        wcnt = 0;
        cmd_ack = 1;
        case (cmd_op)
          8'h83: begin
            tx_seen++;
            if (cmd_nwr != 2'd3 || cmd_nrd != 2'd0 || cmd_par != 24'h0) bad_fmt++;
          end
          8'h12: begin
            poll_seen++;
            if (cmd_nwr != 2'd0 || cmd_nrd != 2'd2) bad_fmt++;
            cmd_rdata = (poll_seen > done_after) ? 16'h0001 : 16'hFFFE;
          end
          8'h02: begin
            clr_seen++;
            clr_par = cmd_par;
            if (cmd_nwr != 2'd2 || cmd_nrd != 2'd0) bad_fmt++;
          end
          default: bad_fmt++;
        endcase
      end
    end
  end

  int t0, tdone;

  task automatic run(input int l, input int da, input bit extra_start);
    lat = l; done_after = da; wcnt = 0;
    tx_seen = 0; poll_seen = 0; clr_seen = 0; bad_fmt = 0; clr_par = 'x;
    @(negedge clk); start = 1; t0 = cyc;
    @(negedge clk); start = 0;
    chk(cmd_req && cmd_op == 8'h83, "R1 req+opcode one cycle after start", int'(cmd_op), 8'h83);
    if (extra_start) begin
      repeat (3) @(negedge clk);
      start = 1; @(negedge clk); start = 0;
    end
    for (int k = 0; k < 5000 && !done; k++) @(negedge clk);
    tdone = cyc;
    chk(done === 1'b1, "R7 done pulse seen", int'(done), 1);
    chk(busy === 1'b0, "R7 busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0, "R7 done one cycle only", int'(done), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!cmd_req && !busy && !done && !ok, "R11 reset state",
        {cmd_req, busy, done, ok}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run(VLAT[v], VDA[v], 1'b0);
      chk(ok == VOK[v][0], "R8 result flag", int'(ok), VOK[v]);
      chk(tx_seen == 1, "R1 one transmit command", tx_seen, 1);
      chk(bad_fmt == 0, "R3 command byte counts", bad_fmt, 0);
      chk(clr_seen == 1 && clr_par == 24'h000100, "R6 clear command bytes",
          int'(clr_par), 24'h000100);
      if (VOK[v] != 0)
        chk(poll_seen == VDA[v] + 1, "R4 polls until bit 0 set", poll_seen, VDA[v] + 1);
      else begin
        chk(tdone - t0 >= TMO, "R5 timeout waits full window", tdone - t0, TMO);
        chk(poll_seen > 1, "R10 timer restarted at start", poll_seen, 2);
      end
      repeat (4) @(negedge clk);
      chk(ok == VOK[v][0], "R8 ok held after done", int'(ok), VOK[v]);
    end

    run(1, 4, 1'b1);
    chk(tx_seen == 1, "R9 start while busy ignored", tx_seen, 1);
    chk(poll_seen == 5, "R9 no extra status reads", poll_seen, 5);
    chk(ok == 1'b1, "R8 success after ignored start", int'(ok), 1);

    lat = 3; done_after = 0; wcnt = 0;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(ok == 1'b0, "R8 ok cleared by new start", int'(ok), 0);
    for (int k = 0; k < 3 && !cmd_ack; k++) begin
      chk(cmd_req && cmd_op == 8'h83, "R2 request held until ack", int'(cmd_op), 8'h83);
      @(negedge clk);
    end
    for (int k = 0; k < 500 && !done; k++) @(negedge clk);
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule